// File: doc/BRIEF.md
# RTC Calibration Clock Generator

This block divides the RTC clock through two chained down-counting prescalers and turns the result into a calibration waveform for a pin. The first stage reloads a 7-bit factor each time it reaches zero. The second stage steps once per first-stage wrap, reloads a 15-bit factor when it reaches zero, and so marks the end of each full period. The block also emits a one-cycle tick at that terminal count; with the usual factors and a 32.768 kHz clock this tick comes once per second.

A source select picks the waveform. In tap mode the output follows one fixed bit of the first-stage counter. With a first factor of 0x7F this gives the RTC clock divided by 64. In chain mode the output has a period of (first factor + 1) × (second factor + 1) clocks, and every rising edge is aligned to the terminal count. The rising edge is therefore the edge to time against. An enable forces the output low. Every output comes from a register, so a factor change cannot make a glitch.

Top module: `rtc_cal_clkout`

## Requirements
- R1: While `cal_en` is 0, `cal_out` is 0 from the next clock onward. The counters keep running.
- R2: With `src_sel` = 0, `cal_out` is a registered copy of bit 5 of the first-stage counter. With `div_a` = 0x7F it has a period of 64 clocks and is high for 32 of them.
- R3: With `src_sel` = 1, the distance between rising edges of `cal_out` is (`div_a`+1)×(`div_s`+1) clocks, for every factor pair except both zero.
- R4: With `src_sel` = 1 held, every rising edge of `cal_out` falls in the same cycle as a `sec_tick` pulse.
- R5: `sec_tick` is a one-cycle pulse every (`div_a`+1)×(`div_s`+1) clocks, whatever `cal_en` and `src_sel` are set to. The second stage moves only on a first-stage wrap.
- R6: Each stage loads its factor only when it reloads, that is on reaching zero. A change to `div_s` first shows in the period after the current one ends. A change to `div_a` first shows at the next first-stage wrap.
- R7: During reset, `cal_out` and `sec_tick` are 0. Reset leaves the chain at its terminal count, so on the first clock after reset `sec_tick` pulses and, in chain mode with `cal_en` = 1, `cal_out` rises.
- R8: With `div_a` = 0x7F, `div_s` = 0xFF and chain mode, the rising edges of `cal_out` are 32768 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_en | input | 1 | Output enable; 0 holds `cal_out` low |
| src_sel | input | 1 | 0: first-stage tap, 1: full chain |
| div_a | input | 7 | First-stage reload factor |
| div_s | input | 15 | Second-stage reload factor |
| cal_out | output | 1 | Calibration waveform |
| sec_tick | output | 1 | One-cycle pulse at the chain terminal count |

## Verification
On every cycle the assertions check four things: the stepping and reloading of each stage, that the output stays low once the enable has dropped, and that a chain-mode rising edge never appears without the terminal-count tick. Other properties show only in the bench's scenarios: the actual periods over a sweep of small factor pairs, the divide-by-64 tap and its duty cycle, the 32768-clock default period, and the points at which a factor change made partway through a period takes effect.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned A_W_DFLT = 7;
  localparam int unsigned S_W_DFLT = 15;

  typedef enum logic {
    SRC_TAP   = 1'b0,
    SRC_CHAIN = 1'b1
  } cal_src_e;
endpackage

// File: rtl/rtc_cal_stage_a.sv
module rtc_cal_stage_a #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = (cnt == '0);

  // Starts at zero so the chain leaves reset at its terminal count.
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= reload_val;
    else           cnt <= cnt - 1'b1;
  end

  AST_A_RELOAD: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == $past(reload_val)); // R6
  AST_A_DOWN: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt == $past(cnt) - 1'b1); // R3
endmodule

// File: rtl/rtc_cal_stage_s.sv
module rtc_cal_stage_s #(
  parameter int unsigned W      = 15,
  parameter logic [W-1:0] RST_LD = W'(8'hFF)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per,
  output logic         term
);
  assign term = step & (cnt == '0);

  // per holds the factor in force for the current full period.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      per <= RST_LD;
    end else if (term) begin
      cnt <= reload_val;
      per <= reload_val;
    end else if (step) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_S_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R5
  AST_S_RELOAD: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == $past(reload_val)) && (per == $past(reload_val))); // R6
endmodule

// File: rtl/rtc_cal_wave.sv
module rtc_cal_wave
  import rtc_cal_pkg::*;
#(
  parameter int unsigned   A_W     = 7,
  parameter int unsigned   S_W     = 15,
  parameter int unsigned   TAP_BIT = 5,
  parameter logic [A_W-1:0] A_RST  = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           sel,
  input  logic [A_W-1:0] a_cnt,
  input  logic [A_W-1:0] a_next,
  input  logic [S_W-1:0] s_cnt,
  input  logic [S_W-1:0] s_per,
  input  logic           term,
  output logic           cal_out,
  output logic           tick
);
  localparam int unsigned AX = A_W + 1;
  localparam int unsigned SX = S_W + 1;

  logic [A_W-1:0] a_per;
  logic [SX-1:0]  s_half;
  logic [SX-1:0]  s_half_up;
  logic [AX-1:0]  a_half_up;
  logic           upper;
  logic           hi_chain;
  logic           tap;
  logic           pick;
  cal_src_e       src;

  // First-stage factor as loaded at the terminal count; fixes the shape for the period.
  always_ff @(posedge clk) begin
    if (rst)       a_per <= A_RST;
    else if (term) a_per <= a_next;
  end

  assign s_half    = {1'b0, s_per} >> 1;
  assign s_half_up = ({1'b0, s_per} + SX'(1)) >> 1;
  assign a_half_up = ({1'b0, a_per} + AX'(1)) >> 1;

  // High phase: the terminal state plus the early part of the next period.
  // The state just before the terminal count is always low, so each period has one rising edge.
  always_comb begin
    if (a_per == '0)      upper = ({1'b0, s_cnt} > s_half_up);
    else if (s_per == '0) upper = ({1'b0, a_cnt} > a_half_up);
    else                  upper = ({1'b0, s_cnt} > s_half);
    hi_chain = term | upper;
  end

  generate
    if (TAP_BIT < A_W) begin : g_tap
      assign tap = a_cnt[TAP_BIT];
    end else begin : g_no_tap
      assign tap = 1'b0;
    end
  endgenerate

  assign src  = cal_src_e'(sel);
  assign pick = (src == SRC_CHAIN) ? hi_chain : tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_out <= 1'b0;
      tick    <= 1'b0;
    end else begin
      cal_out <= en & pick;
      tick    <= term;
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !cal_out); // R1
  AST_RISE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_out) && $past(en, 2) && $past(sel, 2) && $past(sel) |-> tick); // R4
endmodule

// File: rtl/rtc_cal_clkout.sv
module rtc_cal_clkout
  import rtc_cal_pkg::*;
#(
  parameter int unsigned    A_W     = A_W_DFLT,
  parameter int unsigned    S_W     = S_W_DFLT,
  parameter int unsigned    TAP_BIT = 5,
  parameter logic [A_W-1:0] A_RST   = A_W'(7'h7F),
  parameter logic [S_W-1:0] S_RST   = S_W'(8'hFF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cal_en,
  input  logic           src_sel,
  input  logic [A_W-1:0] div_a,
  input  logic [S_W-1:0] div_s,
  output logic           cal_out,
  output logic           sec_tick
);
  logic [A_W-1:0] a_cnt;
  logic           a_wrap;
  logic [S_W-1:0] s_cnt;
  logic [S_W-1:0] s_per;
  logic           term;

  rtc_cal_stage_a #(.W(A_W)) stage_a_i (
    .clk        (clk),
    .rst        (rst),
    .reload_val (div_a),
    .cnt        (a_cnt),
    .wrap       (a_wrap)
  );

  rtc_cal_stage_s #(.W(S_W), .RST_LD(S_RST)) stage_s_i (
    .clk        (clk),
    .rst        (rst),
    .step       (a_wrap),
    .reload_val (div_s),
    .cnt        (s_cnt),
    .per        (s_per),
    .term       (term)
  );

  rtc_cal_wave #(.A_W(A_W), .S_W(S_W), .TAP_BIT(TAP_BIT), .A_RST(A_RST)) wave_i (
    .clk     (clk),
    .rst     (rst),
    .en      (cal_en),
    .sel     (src_sel),
    .a_cnt   (a_cnt),
    .a_next  (div_a),
    .s_cnt   (s_cnt),
    .s_per   (s_per),
    .term    (term),
    .cal_out (cal_out),
    .tick    (sec_tick)
  );
endmodule

// File: tb/rtc_cal_clkout_tb_top.sv
module rtc_cal_clkout_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cal_en;
  logic        src_sel;
  logic [6:0]  div_a;
  logic [14:0] div_s;
  logic        cal_out;
  logic        sec_tick;

  int cyc = 0;
  int n_checks = 0;
  int n_errs = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_cal_clkout dut_i (
    .clk(clk), .rst(rst), .cal_en(cal_en), .src_sel(src_sel),
    .div_a(div_a), .div_s(div_s), .cal_out(cal_out), .sec_tick(sec_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_tick(output int at);
    do @(negedge clk); while (!sec_tick);
    at = cyc;
  endtask

  task automatic wait_cal_rise(output int at, output bit with_tick);
    bit prev;
    do begin
      prev = cal_out;
      @(negedge clk);
    end while (!(cal_out && !prev));
    at = cyc;
    with_tick = sec_tick;
  endtask

  always @(negedge clk) begin
    if (cyc > 190000) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, t4, t5, r1, r2, highs;
    bit tk;
    rst = 1'b1; cal_en = 1'b1; src_sel = 1'b1; div_a = 7'h7F; div_s = 15'h00FF;

    // R7: outputs low during reset
    repeat (3) begin
      @(negedge clk);
      check(cal_out == 1'b0 && sec_tick == 1'b0, "R7 reset low", {cal_out, sec_tick}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(sec_tick == 1'b1, "R7 tick after reset", sec_tick, 1);
    check(cal_out == 1'b1, "R7 rise after reset", cal_out, 1);
    r1 = cyc;

    // R8: default chain period
    wait_cal_rise(r2, tk);
    check(r2 - r1 == 32768, "R8 default period", r2 - r1, 32768);

    // R2: tap mode, divide by 64, half duty
    src_sel = 1'b0;
    wait_cal_rise(r1, tk);
    wait_cal_rise(r1, tk);
    wait_cal_rise(r2, tk);
    check(r2 - r1 == 64, "R2 tap period", r2 - r1, 64);
    highs = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (cal_out) highs++;
    end
    check(highs == 32, "R2 tap duty", highs, 32);

    // R1 and R5: disabled output stays low, tick keeps running
    src_sel = 1'b1; div_a = 7'd2; div_s = 15'd3; cal_en = 1'b0;
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cal_out) highs++;
    end
    check(highs == 0, "R1 disabled low", highs, 0);
    wait_tick(t1);
    wait_tick(t2);
    check(t2 - t1 == 12, "R5 tick while disabled", t2 - t1, 12);
    cal_en = 1'b1;

    // R3, R4, R5: sweep of small factor pairs
    for (int a = 0; a < 6; a++) begin
      for (int s = 0; s < 5; s++) begin
        if (!(a == 0 && s == 0)) begin
          int p;
          p = (a + 1) * (s + 1);
          div_a = 7'(a); div_s = 15'(s);
          wait_tick(t1);
          wait_tick(t1);
          wait_tick(t2);
          check(t2 - t1 == p, "R5 tick period", t2 - t1, p);
          wait_cal_rise(r1, tk);
          check(tk, "R4 rise on tick", tk, 1);
          wait_cal_rise(r2, tk);
          check(r2 - r1 == p, "R3 chain period", r2 - r1, p);
        end
      end
    end

    // R6: factor changes take effect at the next reload
    div_a = 7'd2; div_s = 15'd3;
    wait_tick(t1);
    wait_tick(t1);
    repeat (4) @(negedge clk);
    div_s = 15'd1;
    wait_tick(t2);
    check(t2 - t1 == 12, "R6 second factor defers", t2 - t1, 12);
    wait_tick(t3);
    check(t3 - t2 == 6, "R6 second factor applied", t3 - t2, 6);
    div_a = 7'd4;
    wait_tick(t4);
    check(t4 - t3 == 8, "R6 first factor at next wrap", t4 - t3, 8);
    wait_tick(t5);
    check(t5 - t4 == 10, "R6 first factor applied", t5 - t4, 10);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule